// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed-memory multiprocessor and owns the coherence bookkeeping for a small local memory. It keeps one entry for each memory line. The entry holds a line state (Uncached, Shared or Exclusive), a presence vector with one bit per node, and an owner index that is meaningful when the line is Exclusive. The block also holds the line's data word.

Remote nodes send it three kinds of request: read miss, write miss and data write-back. The controller takes one request at a time. It answers with point-to-point messages on a single output channel:

- a data reply to the requester;
- an invalidate to each sharer that must drop its copy;
- a fetch to the current owner when the memory copy is stale.

The owner answers a fetch on a separate fill input. Because only one transaction is in flight, the acceptance order is the order in which writes to a line take effect. Any request that arrives while a line is waiting on a fetch stays held at the input until the transaction completes.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every line is Uncached with an empty presence vector and a data word of zero. `req_ready` is high and `msg_valid` is low.
- R2: A read miss (`req_type` 0) to an Uncached line produces one data message (`msg_kind` 0) to the requester carrying the stored word. The line becomes Shared with only the requester present.
- R3: A write miss (`req_type` 1) to an Uncached line produces one data message to the requester. The line becomes Exclusive with the requester as owner.
- R4: A read miss to a Shared line produces one data message to the requester and adds the requester to the presence vector. No other message is sent.
- R5: A write miss to a Shared line first sends one invalidate (`msg_kind` 1) per cycle to every present node other than the requester, in ascending node index, clearing each bit as its message goes out. It then sends the data message, and the line becomes Exclusive with the requester as owner.
- R6: A read miss to an Exclusive line sends a fetch (`msg_kind` 2) to the owner and waits for `fill_valid`. It stores `fill_data` in memory and returns that word in a data message. The line becomes Shared with the old owner and the requester present.
- R7: A write miss to an Exclusive line sends a fetch to the owner and stores the fill word in memory. It returns that word to the requester, which becomes the new owner while the line stays Exclusive.
- R8: A write-back (`req_type` 2) from the owner of an Exclusive line stores `req_data` in memory and makes the line Uncached. No message is sent and `req_ready` stays high.
- R9: A write-back from a node that is not the owner, or to a line that is not Exclusive, is dropped. Memory and directory state are unchanged and no message is sent.
- R10: `req_ready` is low from the cycle after a read or write miss is accepted until its data message has been sent. A request held during that time is served afterwards, in acceptance order.
- R11: Every message carries the request's line on `msg_line`. Invalidate and fetch messages carry zero on `msg_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node | input | NODE_W | Requesting node |
| req_line | input | LINE_W | Memory line addressed |
| req_data | input | DATA_W | Write-back data |
| fill_valid | input | 1 | Owner's answer to a fetch |
| fill_data | input | DATA_W | Data returned by the owner |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_kind | output | 2 | 0 data, 1 invalidate, 2 fetch |
| msg_node | output | NODE_W | Destination node |
| msg_line | output | LINE_W | Line the message concerns |
| msg_data | output | DATA_W | Line data for data messages, zero otherwise |

## Verification
A corrupted presence vector does not show up when it is corrupted. It shows up at the next write miss to that line, as an invalidate that is missing, extra or out of order. A stale owner index shows up as a fetch sent to the wrong node on the next miss to an Exclusive line. A wrong state or memory word shows up in the data word, or as a fetch where none was expected, on the very next request to the same line. The bench therefore follows every ownership change with a further request to that line, so each kind of fault reaches the message port within one transaction.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    LS_UNC = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_WBACK = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    MK_DATA  = 2'd0,
    MK_INVAL = 2'd1,
    MK_FETCH = 2'd2
  } msg_kind_e;

  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_INVAL = 3'd1,
    CS_FETCH = 3'd2,
    CS_WAIT  = 3'd3,
    CS_REPLY = 3'd4
  } ctl_st_e;

endpackage

// File: rtl/coh_dir_lowbit.sv
// Lowest-set-bit selector used to order invalidations by node index.
module coh_dir_lowbit #(
  parameter int W = 4,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [W-1:0]     grant,
  output logic [IDX_W-1:0] idx
);

  assign grant = vec & (~vec + W'(1));

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/coh_dir_table.sv
// Per-line directory entry and data word, one read port, one write port.
module coh_dir_table
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  localparam int NODE_W = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  output line_st_e          rd_st,
  output logic [NODES-1:0]  rd_shr,
  output logic [NODE_W-1:0] rd_own,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dir_we,
  input  logic              mem_we,
  input  logic [LINE_W-1:0] wr_line,
  input  line_st_e          wr_st,
  input  logic [NODES-1:0]  wr_shr,
  input  logic [NODE_W-1:0] wr_own,
  input  logic [DATA_W-1:0] wr_data
);

  line_st_e          st_arr  [LINES];
  logic [NODES-1:0]  shr_arr [LINES];
  logic [NODE_W-1:0] own_arr [LINES];
  logic [DATA_W-1:0] dat_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q;
    logic [NODES-1:0]  shr_q;
    logic [NODE_W-1:0] own_q;
    logic [DATA_W-1:0] dat_q;
    logic              dir_en;
    logic              mem_en;

    assign dir_en = dir_we && (wr_line == LINE_W'(g));
    assign mem_en = mem_we && (wr_line == LINE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= LS_UNC;
        shr_q <= '0;
        own_q <= '0;
      end else if (dir_en) begin
        st_q  <= wr_st;
        shr_q <= wr_shr;
        own_q <= wr_own;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q <= '0;
      end else if (mem_en) begin
        dat_q <= wr_data;
      end
    end

    assign st_arr[g]  = st_q;
    assign shr_arr[g] = shr_q;
    assign own_arr[g] = own_q;
    assign dat_arr[g] = dat_q;

    // R2
    shr_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_SHR) |-> (shr_q != '0));

    // R3
    exc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_EXC) |-> ($countones(shr_q) == 1));

    // R7
    exc_owner_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_EXC) |-> shr_q[own_q]);

    // R8
    unc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_UNC) |-> (shr_q == '0));
  end

  assign rd_st   = st_arr[rd_line];
  assign rd_shr  = shr_arr[rd_line];
  assign rd_own  = own_arr[rd_line];
  assign rd_data = dat_arr[rd_line];

endmodule

// File: rtl/coh_dir_ctrl.sv
// Transaction sequencer: one request at a time, invalidations one per cycle.
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  localparam int NODE_W = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [NODE_W-1:0] req_node,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic [LINE_W-1:0] tbl_rd_line,
  input  line_st_e          rd_st,
  input  logic [NODES-1:0]  rd_shr,
  input  logic [NODE_W-1:0] rd_own,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dir_we,
  output logic              mem_we,
  output logic [LINE_W-1:0] wr_line,
  output line_st_e          wr_st,
  output logic [NODES-1:0]  wr_shr,
  output logic [NODE_W-1:0] wr_own,
  output logic [DATA_W-1:0] wr_data,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_node,
  output logic [LINE_W-1:0] msg_line,
  output logic [DATA_W-1:0] msg_data
);

  function automatic logic [NODES-1:0] node_bit(input logic [NODE_W-1:0] n);
    node_bit    = '0;
    node_bit[n] = 1'b1;
  endfunction

  ctl_st_e           cur_q, nxt_st;
  req_kind_e         lat_kind_q, lat_kind_d;
  logic [NODE_W-1:0] lat_node_q, lat_node_d;
  logic [LINE_W-1:0] lat_line_q, lat_line_d;
  logic              lat_en;

  logic [NODES-1:0]  in_bit, lat_bit, in_others, pend, pick, rest;
  logic [NODE_W-1:0] pick_idx;

  assign in_bit    = node_bit(req_node);
  assign lat_bit   = node_bit(lat_node_q);
  assign in_others = rd_shr & ~in_bit;
  assign pend      = rd_shr & ~lat_bit;
  assign rest      = pend & ~pick;

  coh_dir_lowbit #(.W(NODES)) u_pick (
    .vec   (pend),
    .grant (pick),
    .idx   (pick_idx)
  );

  assign req_ready = (cur_q == CS_IDLE);

  always_comb begin
    nxt_st      = cur_q;
    lat_en      = 1'b0;
    lat_kind_d  = req_kind_e'(req_type);
    lat_node_d  = req_node;
    lat_line_d  = req_line;
    tbl_rd_line = (cur_q == CS_IDLE) ? req_line : lat_line_q;
    dir_we      = 1'b0;
    mem_we      = 1'b0;
    wr_line     = tbl_rd_line;
    wr_st       = rd_st;
    wr_shr      = rd_shr;
    wr_own      = rd_own;
    wr_data     = rd_data;
    msg_valid   = 1'b0;
    msg_kind    = MK_DATA;
    msg_node    = lat_node_q;
    msg_line    = lat_line_q;
    msg_data    = '0;

    unique case (cur_q)
      CS_IDLE: begin
        if (req_valid) begin
          unique case (req_type)
            RQ_READ: begin
              lat_en = 1'b1;
              if (rd_st == LS_EXC) begin
                nxt_st = CS_FETCH;
              end else begin
                dir_we = 1'b1;
                wr_st  = LS_SHR;
                wr_shr = (rd_st == LS_SHR) ? (rd_shr | in_bit) : in_bit;
                nxt_st = CS_REPLY;
              end
            end
            RQ_WRITE: begin
              lat_en = 1'b1;
              if (rd_st == LS_EXC) begin
                nxt_st = CS_FETCH;
              end else if ((rd_st == LS_SHR) && (in_others != '0)) begin
                nxt_st = CS_INVAL;
              end else begin
                dir_we = 1'b1;
                wr_st  = LS_EXC;
                wr_shr = in_bit;
                wr_own = req_node;
                nxt_st = CS_REPLY;
              end
            end
            RQ_WBACK: begin
              if ((rd_st == LS_EXC) && (rd_own == req_node)) begin
                dir_we  = 1'b1;
                mem_we  = 1'b1;
                wr_st   = LS_UNC;
                wr_shr  = '0;
                wr_data = req_data;
              end
            end
            default: ;
          endcase
        end
      end
      CS_INVAL: begin
        msg_valid = 1'b1;
        msg_kind  = MK_INVAL;
        msg_node  = pick_idx;
        dir_we    = 1'b1;
        if (rest == '0) begin
          wr_st  = LS_EXC;
          wr_shr = lat_bit;
          wr_own = lat_node_q;
          nxt_st = CS_REPLY;
        end else begin
          wr_shr = rd_shr & ~pick;
        end
      end
      CS_FETCH: begin
        msg_valid = 1'b1;
        msg_kind  = MK_FETCH;
        msg_node  = rd_own;
        nxt_st    = CS_WAIT;
      end
      CS_WAIT: begin
        if (fill_valid) begin
          mem_we  = 1'b1;
          wr_data = fill_data;
          dir_we  = 1'b1;
          if (lat_kind_q == RQ_READ) begin
            wr_st  = LS_SHR;
            wr_shr = node_bit(rd_own) | lat_bit;
          end else begin
            wr_st  = LS_EXC;
            wr_shr = lat_bit;
            wr_own = lat_node_q;
          end
          nxt_st = CS_REPLY;
        end
      end
      CS_REPLY: begin
        msg_valid = 1'b1;
        msg_kind  = MK_DATA;
        msg_data  = rd_data;
        nxt_st    = CS_IDLE;
      end
      default: nxt_st = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= CS_IDLE;
      lat_kind_q <= RQ_READ;
      lat_node_q <= '0;
      lat_line_q <= '0;
    end else begin
      cur_q <= nxt_st;
      if (lat_en) begin
        lat_kind_q <= lat_kind_d;
        lat_node_q <= lat_node_d;
        lat_line_q <= lat_line_d;
      end
    end
  end

  // R5
  inval_skips_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_kind == MK_INVAL)) |-> (msg_node != lat_node_q));

  // R6
  fill_then_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_q == CS_WAIT) && fill_valid) |=> (msg_valid && (msg_kind == MK_DATA)));

endmodule

// File: rtl/coh_home_dir.sv
// Home-node directory controller top.
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  localparam int NODE_W = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [NODE_W-1:0] req_node,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_node,
  output logic [LINE_W-1:0] msg_line,
  output logic [DATA_W-1:0] msg_data
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [LINE_W-1:0] rd_line;
  line_st_e          rd_st;
  logic [NODES-1:0]  rd_shr;
  logic [NODE_W-1:0] rd_own;
  logic [DATA_W-1:0] rd_data;
  logic              dir_we, mem_we;
  logic [LINE_W-1:0] wr_line;
  line_st_e          wr_st;
  logic [NODES-1:0]  wr_shr;
  logic [NODE_W-1:0] wr_own;
  logic [DATA_W-1:0] wr_data;

  coh_dir_table #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_line (rd_line),
    .rd_st   (rd_st),
    .rd_shr  (rd_shr),
    .rd_own  (rd_own),
    .rd_data (rd_data),
    .dir_we  (dir_we),
    .mem_we  (mem_we),
    .wr_line (wr_line),
    .wr_st   (wr_st),
    .wr_shr  (wr_shr),
    .wr_own  (wr_own),
    .wr_data (wr_data)
  );

  coh_dir_ctrl #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_type    (req_type),
    .req_node    (req_node),
    .req_line    (req_line),
    .req_data    (req_data),
    .fill_valid  (fill_valid),
    .fill_data   (fill_data),
    .tbl_rd_line (rd_line),
    .rd_st       (rd_st),
    .rd_shr      (rd_shr),
    .rd_own      (rd_own),
    .rd_data     (rd_data),
    .dir_we      (dir_we),
    .mem_we      (mem_we),
    .wr_line     (wr_line),
    .wr_st       (wr_st),
    .wr_shr      (wr_shr),
    .wr_own      (wr_own),
    .wr_data     (wr_data),
    .msg_valid   (msg_valid),
    .msg_kind    (msg_kind),
    .msg_node    (msg_node),
    .msg_line    (msg_line),
    .msg_data    (msg_data)
  );

  // R10
  ready_after_reply_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(req_ready) |-> ($past(msg_valid) && ($past(msg_kind) == MK_DATA)));

endmodule

// File: tb/coh_home_dir_test.sv
`timescale 1ns/1ps
module coh_home_dir_test;

  localparam int NODES  = 4;
  localparam int LINES  = 8;
  localparam int DATA_W = 16;
  localparam int NODE_W = $clog2(NODES);
  localparam int LINE_W = $clog2(LINES);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_type = '0;
  logic [NODE_W-1:0] req_node = '0;
  logic [LINE_W-1:0] req_line = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic              fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;
  logic              msg_valid;
  logic [1:0]        msg_kind;
  logic [NODE_W-1:0] msg_node;
  logic [LINE_W-1:0] msg_line;
  logic [DATA_W-1:0] msg_data;

  always #10 clk = ~clk;

  coh_home_dir #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_node(req_node), .req_line(req_line), .req_data(req_data),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
    .msg_line(msg_line), .msg_data(msg_data)
  );

  typedef struct packed {
    logic [1:0]        kind;
    logic [NODE_W-1:0] node;
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] data;
  } msg_t;

  msg_t  expq[$];
  string tagq[$];
  int    checks = 0;
  int    errors = 0;
  logic  mon_on = 1'b0;
  logic  fill_arm = 1'b0;
  int    resp_seq = 0;
  int    model_seq = 0;

  // Reference directory kept from the requirements: 0 Uncached, 1 Shared, 2 Exclusive
  int                m_st  [LINES];
  logic [NODES-1:0]  m_sh  [LINES];
  int                m_own [LINES];
  logic [DATA_W-1:0] m_mem [LINES];

  task automatic push(input int kind, input int node, input int line,
                      input logic [DATA_W-1:0] data, input string tag);
    msg_t m;
    m.kind = 2'(kind);
    m.node = NODE_W'(node);
    m.line = LINE_W'(line);
    m.data = data;
    expq.push_back(m);
    tagq.push_back(tag);
  endtask

  task automatic model(input int kind, input int node, input int line,
                       input logic [DATA_W-1:0] data, input string tag);
    logic [DATA_W-1:0] fv;
    if (kind == 2) begin
      if (m_st[line] == 2 && m_own[line] == node) begin
        m_mem[line] = data;
        m_st[line]  = 0;
        m_sh[line]  = '0;
      end
    end else if (m_st[line] == 2) begin
      fv = DATA_W'(16'hA000 + model_seq);
      model_seq++;
      push(2, m_own[line], line, '0, tag);
      m_mem[line] = fv;
      push(0, node, line, fv, tag);
      if (kind == 0) begin
        m_sh[line] = '0;
        m_sh[line][m_own[line]] = 1'b1;
        m_sh[line][node] = 1'b1;
        m_st[line] = 1;
      end else begin
        m_sh[line] = '0;
        m_sh[line][node] = 1'b1;
        m_own[line] = node;
      end
    end else if (kind == 0) begin
      push(0, node, line, m_mem[line], tag);
      if (m_st[line] == 0) m_sh[line] = '0;
      m_sh[line][node] = 1'b1;
      m_st[line] = 1;
    end else begin
      if (m_st[line] == 1) begin
        for (int i = 0; i < NODES; i++)
          if (m_sh[line][i] && i != node) push(1, i, line, '0, tag);
      end
      push(0, node, line, m_mem[line], tag);
      m_st[line] = 2;
      m_sh[line] = '0;
      m_sh[line][node] = 1'b1;
      m_own[line] = node;
    end
  endtask

  // Driver: updates the model, then holds the request until it is taken.
  task automatic issue(input int kind, input int node, input int line,
                       input logic [DATA_W-1:0] data, input string tag);
    logic was_ready;
    model(kind, node, line, data, tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_type  = 2'(kind);
    req_node  = NODE_W'(node);
    req_line  = LINE_W'(line);
    req_data  = data;
    forever begin
      was_ready = req_ready;
      @(negedge clk);
      if (was_ready) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (expq.size() != 0 || !req_ready || fill_arm || fill_valid);
  endtask

  // Monitor: compares each message with the queue and answers fetches.
  always @(negedge clk) begin
    if (fill_valid) fill_valid = 1'b0;
    if (fill_arm) begin
      fill_valid = 1'b1;
      fill_data  = DATA_W'(16'hA000 + resp_seq);
      resp_seq++;
      fill_arm   = 1'b0;
    end
    if (mon_on && msg_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL unexpected message: actual kind=%0d node=%0d line=%0d data=%h, expected none",
                 msg_kind, msg_node, msg_line, msg_data);
      end else begin
        msg_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (e.kind != msg_kind || e.node != msg_node || e.line != msg_line || e.data != msg_data) begin
          errors++;
          $display("FAIL %s: actual kind=%0d node=%0d line=%0d data=%h, expected kind=%0d node=%0d line=%0d data=%h",
                   t, msg_kind, msg_node, msg_line, msg_data, e.kind, e.node, e.line, e.data);
        end
      end
      if (msg_kind == 2'd2) fill_arm = 1'b1;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_st[i] = 0; m_sh[i] = '0; m_own[i] = 0; m_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state at the ports
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check(msg_valid == 1'b0, "R1 no message", int'(msg_valid), 0);
    mon_on = 1'b1;

    issue(0, 0, 1, '0, "R1 R2 read uncached zero data");
    wait_idle();
    issue(0, 2, 1, '0, "R4 read shared");
    wait_idle();
    issue(0, 3, 1, '0, "R4 read shared");
    wait_idle();
    issue(1, 2, 1, '0, "R5 R11 invalidate others ascending");
    wait_idle();
    issue(0, 1, 1, '0, "R6 read exclusive fetch");
    wait_idle();
    issue(1, 1, 1, '0, "R5 requester keeps copy");
    wait_idle();
    issue(1, 3, 1, '0, "R7 write exclusive fetch");
    wait_idle();

    issue(2, 1, 1, 16'h1234, "R9");
    @(negedge clk);
    check(req_ready && !msg_valid, "R9 non-owner write-back quiet", int'(msg_valid), 0);
    issue(2, 3, 1, 16'h5678, "R8");
    @(negedge clk);
    check(req_ready && !msg_valid, "R8 owner write-back quiet", int'(msg_valid), 0);
    issue(0, 0, 1, '0, "R8 R2 read after write-back");
    wait_idle();

    issue(2, 0, 3, 16'hBEEF, "R9");
    @(negedge clk);
    check(req_ready && !msg_valid, "R9 write-back to uncached quiet", int'(msg_valid), 0);
    issue(1, 2, 3, '0, "R3 R9 write uncached");
    wait_idle();
    issue(1, 2, 6, '0, "R3 write uncached second line");
    wait_idle();
    issue(1, 1, 6, '0, "R7 ownership moves");
    wait_idle();

    // R10: second request held while the first waits on its fetch
    issue(0, 0, 3, '0, "R10 R6 first of pair");
    check(req_ready == 1'b0, "R10 busy after accept", int'(req_ready), 0);
    issue(1, 1, 3, '0, "R10 R5 held request");
    wait_idle();
    issue(0, 3, 3, '0, "R10 R6 follow-up");
    wait_idle();

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R10 all expected messages seen", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule